// File: doc/BRIEF.md
# Slave Serial Audio Transmitter

This block drives stereo PCM samples onto a single serial data line for a receiver that owns the bit clock and the frame-sync. It runs directly on the incoming bit clock. It watches the frame-sync line for edges and, once per frame, takes one left/right sample pair through a ready/valid handshake. It then shifts each word out MSB first, placed in time so that the receiver captures every bit on its chosen capture edge.

Three framings are available. Two are level-framed, where frame-sync selects the channel: one with the MSB one bit late, one with the MSB on the first bit. The third is pulse-framed, where a one-bit pulse starts the frame and the right word follows the left word directly. The pulse-framed mode has a selectable one-bit MSB delay. Word length, format and delay are sampled only when a frame begins, so a frame in flight is always finished under the settings it started with.

Top module: `aud_ser_tx`

## Requirements
- R1: While rst_ni is low, sdata_o, underrun_o and smp_ready_o are all 0.
- R2: Every word is shifted out MSB first, with each following bit in order down to the LSB.
- R3: With fmt_i = 0, a frame starts where frame-sync is first sampled low after being high. The left word goes out while frame-sync is low and the right word while it is high. In each half the MSB is driven one launch edge after the launch edge that first samples the new level.
- R4: With fmt_i = 1, a frame starts where frame-sync is first sampled high after being low. The left word goes out while frame-sync is high and the right word while it is low. In each half the MSB is driven on the launch edge that first samples the new level.
- R5: With fmt_i = 2 or 3, a frame starts on the launch edge that samples a rising frame-sync pulse. The left word is sent, and the right word follows with no gap. When dsp_late_i = 0, the left MSB is driven on that launch edge; when dsp_late_i = 1, it is driven one launch edge later.
- R6: wlen_i codes 0, 1, 2 and 3 select 8, 16, 20 and 24 bit words. The word is taken from the low bits of each 24-bit sample field.
- R7: Every launch edge after the LSB, up to the next channel or frame boundary, drives sdata_o to 0.
- R8: With cap_fall_i = 0, frame-sync is sampled and sdata_o changes on falling sclk_i edges, so that the receiver captures on rising edges. With cap_fall_i = 1, both happen on rising edges. cap_fall_i may change only while in reset.
- R9: smp_ready_o is high only in the half bit period before a frame-starting launch edge. When smp_valid_i is high at that edge, both sample words are taken.
- R10: If smp_valid_i is low at a frame start, the frame carries all-zero words, and underrun_o is high from that edge until the next frame start.
- R11: fmt_i, wlen_i and dsp_late_i are sampled only at a frame start. Frame starts are detected with the format currently in force (before the first frame start, the live format).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Bit clock from the receiver |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync from the receiver |
| cap_fall_i | input | 1 | 1 = receiver captures on falling edge |
| fmt_i | input | 2 | 0 level/late MSB, 1 level/early MSB, 2-3 pulse |
| wlen_i | input | 2 | Word length code |
| dsp_late_i | input | 1 | Pulse mode: MSB one bit late |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Pair taken at the coming launch edge |
| smp_left_i | input | MAX_WL | Left sample, right-aligned |
| smp_right_i | input | MAX_WL | Right sample, right-aligned |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame carries no valid pair |

## Verification
If the bit position or the channel select is wrong inside the block, the fault appears on sdata_o at the very next capture edge. A wrong position shows as a shifted or truncated word; a wrong channel select shows as the other channel's bits. The reference model predicts every bit on every capture edge, so a slip of a single bit is reported in the cycle it happens. A configuration latched at the wrong moment changes the word length or MSB delay in the middle of a frame, and that is visible within that same frame. A bad underrun state shows on underrun_o one half period after the frame-starting edge.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S     = 2'd0,
    FMT_LJ      = 2'd1,
    FMT_DSP     = 2'd2,
    FMT_DSP_ALT = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wl;
    logic       late;
  } cfg_t;

  function automatic int unsigned wl_bits(logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic is_dsp(fmt_e f);
    return f[1];
  endfunction

  // launch edges between boundary detect and MSB
  function automatic int unsigned lead_dly(cfg_t c);
    if (is_dsp(c.fmt)) return c.late ? 1 : 0;
    return (c.fmt == FMT_I2S) ? 1 : 0;
  endfunction
endpackage

// File: rtl/atx_fs_detect.sv
module atx_fs_detect
  import atx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  fmt_e fmt_i,
  output logic fstart_o,
  output logic half_o
);
  logic fs_q, vld_q, rise, fall;

  assign rise     = vld_q & fsync_i & ~fs_q;
  assign fall     = vld_q & ~fsync_i & fs_q;
  assign fstart_o = (fmt_i == FMT_I2S) ? fall : rise;
  assign half_o   = is_dsp(fmt_i) ? 1'b0 : ((fmt_i == FMT_I2S) ? rise : fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      fs_q  <= fsync_i;
      vld_q <= 1'b1;
    end
  end

  // R9
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstart_o |=> !fstart_o);
endmodule

// File: rtl/atx_cfg_hold.sv
module atx_cfg_hold
  import atx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fstart_i,
  input  cfg_t live_i,
  output fmt_e det_fmt_o,
  output cfg_t use_o
);
  cfg_t cfg_q;
  logic run_q;

  assign det_fmt_o = run_q ? cfg_q.fmt : live_i.fmt;
  assign use_o     = fstart_i ? live_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{fmt: FMT_I2S, wl: 2'd3, late: 1'b0};
      run_q <= 1'b0;
    end else if (fstart_i) begin
      cfg_q <= live_i;
      run_q <= 1'b1;
    end
  end

  // R11
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !fstart_i) |=> $stable(cfg_q));
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
  import atx_pkg::*;
#(
  parameter int MAX_WL = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fstart_i,
  input  logic              half_i,
  input  cfg_t              cfg_i,
  input  logic              smp_valid_i,
  input  logic [MAX_WL-1:0] left_i,
  input  logic [MAX_WL-1:0] right_i,
  output logic              sdata_o,
  output logic              underrun_o
);
  localparam int IDX_MAX = 2 * MAX_WL + 1;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam int SW      = $clog2(MAX_WL);

  logic [MAX_WL-1:0] left_q, right_q, l_n, r_n, word;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              chan_q, chan_n, sdata_q, bit_n, unr_q;

  always_comb begin
    int w, d, b, ix;
    if (fstart_i || half_i)            idx_n = '0;
    else if (idx_q == IDX_W'(IDX_MAX)) idx_n = idx_q;
    else                               idx_n = idx_q + 1'b1;
    chan_n = fstart_i ? 1'b0 : (half_i ? 1'b1 : chan_q);
    l_n    = fstart_i ? (smp_valid_i ? left_i  : '0) : left_q;
    r_n    = fstart_i ? (smp_valid_i ? right_i : '0) : right_q;
    word   = chan_n ? r_n : l_n;
    w      = int'(wl_bits(cfg_i.wl));
    d      = int'(lead_dly(cfg_i));
    ix     = int'(idx_n);
    b      = 0;
    bit_n  = 1'b0;
    if (ix >= d) begin
      b = ix - d;
      if (is_dsp(cfg_i.fmt)) begin
        if (b < w)          bit_n = l_n[SW'(w - 1 - b)];
        else if (b < 2 * w) bit_n = r_n[SW'(2 * w - 1 - b)];
      end else if (b < w) begin
        bit_n = word[SW'(w - 1 - b)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      chan_q  <= 1'b0;
      idx_q   <= IDX_W'(IDX_MAX);
      sdata_q <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      left_q  <= l_n;
      right_q <= r_n;
      chan_q  <= chan_n;
      idx_q   <= idx_n;
      sdata_q <= bit_n;
      if (fstart_i) unr_q <= ~smp_valid_i;
    end
  end

  assign sdata_o    = sdata_q;
  assign underrun_o = unr_q;

  // R7
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == IDX_W'(IDX_MAX)) |-> !sdata_q);
  // R10
  unr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fstart_i && !smp_valid_i) |=> underrun_o);
  // R10
  unr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fstart_i |=> $stable(underrun_o));
  // R3
  left_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstart_i |=> (chan_q == 1'b0));
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import atx_pkg::*;
#(
  parameter int MAX_WL = 24
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              cap_fall_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              dsp_late_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [MAX_WL-1:0] smp_left_i,
  input  logic [MAX_WL-1:0] smp_right_i,
  output logic              sdata_o,
  output logic              underrun_o
);
  logic lclk, fstart, half;
  cfg_t live, cfg_use;
  fmt_e det_fmt;

  // launch edge is opposite the capture edge; select is static
  assign lclk = cap_fall_i ? sclk_i : ~sclk_i;
  assign live = {fmt_e'(fmt_i), wlen_i, dsp_late_i};

  atx_fs_detect u_fs (
    .clk_i(lclk), .rst_ni(rst_ni), .fsync_i(fsync_i), .fmt_i(det_fmt),
    .fstart_o(fstart), .half_o(half)
  );

  atx_cfg_hold u_cfg (
    .clk_i(lclk), .rst_ni(rst_ni), .fstart_i(fstart), .live_i(live),
    .det_fmt_o(det_fmt), .use_o(cfg_use)
  );

  atx_serializer #(.MAX_WL(MAX_WL)) u_ser (
    .clk_i(lclk), .rst_ni(rst_ni), .fstart_i(fstart), .half_i(half),
    .cfg_i(cfg_use), .smp_valid_i(smp_valid_i), .left_i(smp_left_i),
    .right_i(smp_right_i), .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  assign smp_ready_o = fstart & rst_ni;

  // R9
  ready_pulse_chk: assert property (@(posedge lclk) disable iff (!rst_ni)
    smp_ready_o |=> !smp_ready_o);
endmodule

// File: tb/aud_ser_tx_bench.sv
`timescale 1ns/1ps
module aud_ser_tx_bench;
  logic        sclk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync_i = 1'b1;
  logic        cap_fall_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [1:0]  wlen_i = 2'd3;
  logic        dsp_late_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [23:0] smp_left_i = '0;
  logic [23:0] smp_right_i = '0;
  logic        sdata_o, underrun_o;

  always #2 sclk = ~sclk;

  aud_ser_tx u_aud_ser_tx (
    .sclk_i(sclk), .rst_ni(rst_ni), .fsync_i(fsync_i), .cap_fall_i(cap_fall_i),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .dsp_late_i(dsp_late_i),
    .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .smp_left_i(smp_left_i), .smp_right_i(smp_right_i),
    .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // stimulus settings
  logic [1:0] cf_fmt = 2'd0, cf_wl = 2'd3;
  logic       cf_late = 1'b0, v_en = 1'b1;
  int         n_pair = 0;

  // reference model state
  bit         m_vld, m_run, m_unr, exp_sd;
  logic       m_prev;
  logic [1:0] m_fmt, m_wl;
  logic       m_late;
  logic [23:0] m_l, m_r;
  bit         exp_q[$];

  function automatic logic [23:0] pair_l(int n);
    return 24'hA5C31E ^ (24'(n) * 24'h0136B7);
  endfunction
  function automatic logic [23:0] pair_r(int n);
    return ~pair_l(n) ^ 24'h3C0F00;
  endfunction
  function automatic int wbits(logic [1:0] c);
    return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 20 : 24;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_word(logic [23:0] w, int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  function automatic bit model_start(logic fs);
    logic [1:0] ef;
    if (!m_vld) return 0;
    ef = m_run ? m_fmt : cf_fmt;
    return (ef == 0) ? (m_prev && !fs) : (!m_prev && fs);
  endfunction

  task automatic model_step(logic fs);
    logic [1:0] ef;
    bit st, hf;
    if (!m_vld) begin
      m_vld = 1; m_prev = fs;
      exp_sd = 0;
      return;
    end
    ef = m_run ? m_fmt : cf_fmt;
    st = model_start(fs);
    hf = !st && (ef < 2) && ((ef == 0) ? (!m_prev && fs) : (m_prev && !fs));
    if (st) begin
      m_fmt = cf_fmt; m_wl = cf_wl; m_late = cf_late; m_run = 1;
      if (v_en) begin m_l = pair_l(n_pair); m_r = pair_r(n_pair); n_pair++; m_unr = 0; end
      else begin m_l = '0; m_r = '0; m_unr = 1; end
      exp_q.delete();
      if (m_fmt == 0 || (m_fmt >= 2 && m_late)) exp_q.push_back(0);
      push_word(m_l, wbits(m_wl));
      if (m_fmt >= 2) push_word(m_r, wbits(m_wl));
    end else if (hf) begin
      exp_q.delete();
      if (m_fmt == 0) exp_q.push_back(0);
      push_word(m_r, wbits(m_wl));
    end
    exp_sd = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
    m_prev = fs;
  endtask

  task automatic wait_cap();
    if (cap_fall_i) @(negedge sclk); else @(posedge sclk);
  endtask

  task automatic drive(logic fs);
    fsync_i = fs; fmt_i = cf_fmt; wlen_i = cf_wl; dsp_late_i = cf_late;
    smp_valid_i = v_en; smp_left_i = pair_l(n_pair); smp_right_i = pair_r(n_pair);
  endtask

  task automatic tick(logic fs);
    bit st;
    wait_cap();
    chk(sdata_o === exp_sd, cur_tag, int'(sdata_o), int'(exp_sd));
    chk(underrun_o === m_unr, "R10", int'(underrun_o), int'(m_unr));
    drive(fs);
    #1;
    st = model_start(fs);
    chk(smp_ready_o === st, "R9", int'(smp_ready_o), int'(st));
    model_step(fs);
  endtask

  task automatic do_reset(logic cf, logic idle_fs);
    rst_ni = 1'b0; cap_fall_i = cf; drive(idle_fs);
    #20;
    chk(sdata_o === 1'b0, "R1", int'(sdata_o), 0);
    chk(underrun_o === 1'b0, "R1", int'(underrun_o), 0);
    chk(smp_ready_o === 1'b0, "R1", int'(smp_ready_o), 0);
    m_vld = 0; m_run = 0; m_unr = 0; exp_sd = 0; m_prev = idle_fs;
    m_fmt = 0; m_wl = 3; m_late = 0; m_l = '0; m_r = '0; exp_q.delete();
    wait_cap();
    rst_ni = 1'b1;
    #1 model_step(idle_fs);
  endtask

  task automatic lvl_frames(int n, int slot, logic first);
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < slot; i++) tick(first);
      for (int i = 0; i < slot; i++) tick(!first);
    end
  endtask

  task automatic dsp_frames(int n, int len);
    for (int f = 0; f < n; f++) begin
      tick(1'b1);
      for (int i = 1; i < len; i++) tick(1'b0);
    end
  endtask

  initial begin
    // phase A: capture on rising edge (R8)
    cf_fmt = 0; cf_wl = 3;
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b1);
    cur_tag = "R3 R2 R6 R8";
    lvl_frames(3, 32, 1'b0);
    // config change mid-frame waits for next frame start
    cur_tag = "R11";
    for (int i = 0; i < 32; i++) begin
      if (i == 10) cf_wl = 2'd1;
      tick(1'b0);
    end
    for (int i = 0; i < 32; i++) tick(1'b1);
    lvl_frames(1, 32, 1'b0);
    cur_tag = "R10";
    v_en = 1'b0;
    lvl_frames(1, 20, 1'b0);
    v_en = 1'b1;
    lvl_frames(1, 20, 1'b0);
    cur_tag = "R4 R2 R6";
    cf_fmt = 1; cf_wl = 1;
    lvl_frames(3, 20, 1'b1);
    cur_tag = "R7";
    cf_wl = 0;
    lvl_frames(3, 12, 1'b1);
    cur_tag = "R5 R6";
    cf_fmt = 2; cf_wl = 2; cf_late = 0;
    dsp_frames(3, 48);
    cur_tag = "R5";
    cf_fmt = 3; cf_wl = 0; cf_late = 1;
    dsp_frames(3, 20);
    // phase B: capture on falling edge (R8)
    cf_fmt = 0; cf_wl = 1; cf_late = 0;
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b1);
    cur_tag = "R8 R3";
    lvl_frames(2, 18, 1'b0);
    cur_tag = "R8 R5";
    cf_fmt = 2; cf_wl = 3; cf_late = 1;
    dsp_frames(3, 50);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule